// File: doc/BRIEF.md
# Fault escalation controller

This block sits between the places in a processor core that raise exceptions and the interrupt sequencer that enters a handler. A raised exception arrives as a one-cycle request carrying a vector number, an error code, the protection-enable state and the instruction pointer saved at the start of the faulting instruction. The controller keeps a count of exceptions that have been raised but not yet delivered. Any fault raised while an earlier one is still outstanding is delivered as a double fault. A fault that would make the count reach its limit skips delivery and resets the core instead.

For each delivery the controller pulses a restore of the instruction pointer and holds a delivery request to the sequencer until it is acknowledged, with the result reported as success or failure. If the vector is one that carries an error code and protection is enabled, it then holds a push request with that code until the push is acknowledged. The count goes back to zero only when the whole delivery succeeds. A failed step returns the controller to idle and leaves the count raised, so the next fault escalates. A new request that arrives while a delivery is still in progress abandons that delivery and is handled as a nested fault.

Top module: `fault_escalator`

## Requirements
- R1: After reset `dlv_req`, `push_req`, `ip_load` and `core_rst` are low and `fault_depth` is 0.
- R2: A request in a cycle where `fault_depth` is below LIMIT-1 (default LIMIT 3) raises `fault_depth` by one in the following cycle.
- R3: The delivered vector is the request's `exc_vec` when the raised depth is 1, and DF_VEC (default 8) when the raised depth is greater than 1.
- R4: A request that raises the depth to LIMIT pulses `core_rst` high for one cycle in the next cycle, starts no delivery (`dlv_req` and `push_req` low), and clears `fault_depth` to 0.
- R5: A request that starts a delivery pulses `ip_load` for exactly the first cycle of `dlv_req`, with `ip_value` equal to the `saved_ip` that came with the request.
- R6: After `dlv_ack` with `dlv_ok`=1, `push_req` rises in the next cycle only if the delivered vector is 8, 10, 11, 12, 13, 14 or 17 and `prot_en` was 1 with the request. `push_data` is then the request's `exc_err`.
- R7: `fault_depth` becomes 0 in the cycle after the last step succeeds. That step is either the entry acknowledge with no push due, or the push acknowledge with `push_ok`=1. After an acknowledge with the ok bit 0, the controller returns to idle and `fault_depth` keeps its value.
- R8: A request while `dlv_req` or `push_req` is high abandons the delivery in progress and is handled as a nested fault under R2 to R4. An acknowledge in that same cycle is ignored.
- R9: `dlv_req` with `dlv_vec`, and `push_req` with `push_data`, stay high and stable until their acknowledge arrives. The two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_vec | input | VEC_W | Vector of the raised exception |
| exc_err | input | ERR_W | Error code of the raised exception |
| prot_en | input | 1 | Protection enabled, sampled with the request |
| saved_ip | input | IP_W | Instruction pointer at the start of the faulting instruction |
| ip_load | output | 1 | Pulse: restore the instruction pointer to `ip_value` |
| ip_value | output | IP_W | Instruction pointer to restore |
| dlv_req | output | 1 | Request to the sequencer to enter the handler for `dlv_vec` |
| dlv_vec | output | VEC_W | Vector to deliver |
| dlv_ack | input | 1 | Sequencer finished the entry attempt |
| dlv_ok | input | 1 | Entry succeeded, valid with `dlv_ack` |
| push_req | output | 1 | Request to push `push_data` on the handler stack |
| push_data | output | ERR_W | Error code to push |
| push_ack | input | 1 | Push attempt finished |
| push_ok | input | 1 | Push succeeded, valid with `push_ack` |
| core_rst | output | 1 | One-cycle reset request on a triple fault |
| fault_depth | output | $clog2(LIMIT+1) | Number of outstanding exceptions |

## Verification
The bench looks for off-by-one escalation. A controller that compared the depth before the raise rather than after it would deliver a plain second fault, or would reset on the second fault instead of the third. It targets a push failure after a successful entry, which a faulty design might still count as success and so clear the depth. It covers the edges of the error-code set (vectors 9, 15, 17, 18 and one above 31), and a fault with protection off that must not push. It also raises a request in the same cycle as an acknowledge, where a design that let the acknowledge win would clear the depth or lose the nested fault.

// File: rtl/fesc_pkg.sv
package fesc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_PUSH  = 2'd2
  } fesc_state_e;
endpackage

// File: rtl/fesc_depth_counter.sv
// Outstanding-exception counter; clear wins over increment.
module fesc_depth_counter #(
  parameter int LIMIT = 3,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] depth_q,
  output logic [CW-1:0] depth_raised,
  output logic          at_limit
);
  logic [CW-1:0] depth_d;

  assign depth_raised = depth_q + 1'b1;
  assign at_limit     = (int'(depth_raised) >= LIMIT);

  always_comb begin
    depth_d = depth_q;
    if (clr)      depth_d = '0;
    else if (inc) depth_d = depth_raised;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= '0;
    else        depth_q <= depth_d;
  end
endmodule

// File: rtl/fesc_errcode_lut.sv
// Flags vectors that carry an error code, from a bit mask over the low 32 vectors.
module fesc_errcode_lut #(
  parameter int          VEC_W     = 8,
  parameter logic [31:0] CODE_MASK = 32'h0002_7D00
) (
  input  logic [VEC_W-1:0] vec,
  output logic             has_code
);
  logic in_range;

  generate
    if (VEC_W > 5) begin : g_wide
      assign in_range = (vec[VEC_W-1:5] == '0);
    end else begin : g_narrow
      assign in_range = 1'b1;
    end
  endgenerate

  assign has_code = in_range & CODE_MASK[vec[4:0]];
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int VEC_W  = 8,
  parameter int ERR_W  = 32,
  parameter int IP_W   = 32,
  parameter int LIMIT  = 3,
  parameter int DF_VEC = 8,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_vec,
  input  logic [ERR_W-1:0] exc_err,
  input  logic             prot_en,
  input  logic [IP_W-1:0]  saved_ip,
  output logic             ip_load,
  output logic [IP_W-1:0]  ip_value,
  output logic             dlv_req,
  output logic [VEC_W-1:0] dlv_vec,
  input  logic             dlv_ack,
  input  logic             dlv_ok,
  output logic             push_req,
  output logic [ERR_W-1:0] push_data,
  input  logic             push_ack,
  input  logic             push_ok,
  output logic             core_rst,
  output logic [CW-1:0]    fault_depth
);
  import fesc_pkg::*;

  fesc_state_e      state_q, state_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [ERR_W-1:0] err_q;
  logic [IP_W-1:0]  ip_q;
  logic             prot_q;
  logic             ip_load_q, rst_q;
  logic             accept, escalate, success, depth_clr;
  logic [CW-1:0]    depth_q, depth_raised;
  logic             at_limit, code_hit;

  fesc_depth_counter #(.LIMIT(LIMIT)) u_depth (
    .clk          (clk),
    .rst_n        (rst_n),
    .inc          (exc_req),
    .clr          (depth_clr),
    .depth_q      (depth_q),
    .depth_raised (depth_raised),
    .at_limit     (at_limit)
  );

  fesc_errcode_lut #(.VEC_W(VEC_W)) u_lut (
    .vec      (vec_q),
    .has_code (code_hit)
  );

  assign escalate  = exc_req & at_limit;
  assign accept    = exc_req & ~at_limit;
  assign depth_clr = escalate | success;
  assign vec_d     = (int'(depth_raised) > 1) ? VEC_W'(DF_VEC) : exc_vec;

  // Next state: a new request overrides any acknowledge in the same cycle.
  always_comb begin
    state_d = state_q;
    success = 1'b0;
    unique case (state_q)
      ST_ENTRY: begin
        if (dlv_ack) begin
          if (dlv_ok && code_hit && prot_q) begin
            state_d = ST_PUSH;
          end else begin
            state_d = ST_IDLE;
            success = dlv_ok;
          end
        end
      end
      ST_PUSH: begin
        if (push_ack) begin
          state_d = ST_IDLE;
          success = push_ok;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (exc_req) begin
      success = 1'b0;
      state_d = at_limit ? ST_IDLE : ST_ENTRY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ip_load_q <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      ip_load_q <= accept;
      rst_q     <= escalate;
    end
  end

  // Captured delivery context, loaded only on an accepted request.
  always_ff @(posedge clk) begin
    if (accept) begin
      vec_q  <= vec_d;
      err_q  <= exc_err;
      prot_q <= prot_en;
      ip_q   <= saved_ip;
    end
  end

  assign dlv_req     = (state_q == ST_ENTRY);
  assign push_req    = (state_q == ST_PUSH);
  assign dlv_vec     = vec_q;
  assign push_data   = err_q;
  assign ip_value    = ip_q;
  assign ip_load     = ip_load_q;
  assign core_rst    = rst_q;
  assign fault_depth = depth_q;

  a_r4_reset_no_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (!dlv_req && !push_req && fault_depth == '0));

  a_r5_restore_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ip_load |-> dlv_req);

  a_r3_double_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_req && int'(fault_depth) > 1) |-> (dlv_vec == VEC_W'(DF_VEC)));

  a_r2_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && int'(fault_depth) < LIMIT - 1) |=> (fault_depth == $past(fault_depth) + 1'b1));

  a_r7_fail_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_req && dlv_ack && !dlv_ok && !exc_req) |=> (!dlv_req && fault_depth == $past(fault_depth)));

  a_r9_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_req && !dlv_ack && !exc_req) |=> (dlv_req && $stable(dlv_vec)));

  a_r9_push_held: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !push_ack && !exc_req) |=> (push_req && $stable(push_data)));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dlv_req && push_req));

  a_r6_push_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (code_hit && prot_q));
endmodule

// File: tb/fault_escalator_bench.sv
module fault_escalator_bench;
  localparam int VW = 8, EW = 32, IW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exc_req = 1'b0;
  logic [VW-1:0] exc_vec = '0;
  logic [EW-1:0] exc_err = '0;
  logic          prot_en = 1'b0;
  logic [IW-1:0] saved_ip = '0;
  logic          dlv_ack = 1'b0, dlv_ok = 1'b0, push_ack = 1'b0, push_ok = 1'b0;
  logic          ip_load, dlv_req, push_req, core_rst;
  logic [IW-1:0] ip_value;
  logic [VW-1:0] dlv_vec;
  logic [EW-1:0] push_data;
  logic [1:0]    fault_depth;

  int tests = 0, fails = 0, cycles = 0;

  fault_escalator u_fault_escalator (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec), .exc_err(exc_err),
    .prot_en(prot_en), .saved_ip(saved_ip), .ip_load(ip_load), .ip_value(ip_value),
    .dlv_req(dlv_req), .dlv_vec(dlv_vec), .dlv_ack(dlv_ack), .dlv_ok(dlv_ok),
    .push_req(push_req), .push_data(push_data), .push_ack(push_ack), .push_ok(push_ok),
    .core_rst(core_rst), .fault_depth(fault_depth)
  );

  always #4 clk = ~clk;

  // Reference model: 0 idle, 1 entry, 2 push
  int  m_state = 0, m_depth = 0, m_vec = 0, m_err = 0, m_ip = 0;
  bit  m_prot = 0, m_ipl = 0, m_rst = 0;

  function automatic bit carries_code(int v);
    return (v == 8) || (v >= 10 && v <= 14) || (v == 17);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_depth = 0; m_ipl = 0; m_rst = 0;
    end else begin
      m_ipl = 0; m_rst = 0;
      if (exc_req) begin
        if (m_depth + 1 >= 3) begin
          m_depth = 0; m_state = 0; m_rst = 1;
        end else begin
          m_depth = m_depth + 1;
          m_vec   = (m_depth > 1) ? 8 : int'(exc_vec);
          m_err   = int'(exc_err); m_prot = prot_en; m_ip = int'(saved_ip);
          m_ipl   = 1; m_state = 1;
        end
      end else if (m_state == 1 && dlv_ack) begin
        if (dlv_ok && carries_code(m_vec) && m_prot) m_state = 2;
        else begin
          if (dlv_ok) m_depth = 0;
          m_state = 0;
        end
      end else if (m_state == 2 && push_ack) begin
        if (push_ok) m_depth = 0;
        m_state = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1 dlv_req", int'(dlv_req), 0);
      chk("R1 push_req", int'(push_req), 0);
      chk("R1 core_rst", int'(core_rst), 0);
      chk("R1 depth", int'(fault_depth), 0);
    end else begin
      chk("R2/R7 depth", int'(fault_depth), m_depth);
      chk("R9 dlv_req", int'(dlv_req), int'(m_state == 1));
      chk("R6 push_req", int'(push_req), int'(m_state == 2));
      chk("R4 core_rst", int'(core_rst), int'(m_rst));
      chk("R5 ip_load", int'(ip_load), int'(m_ipl));
      if (m_state == 1) chk("R3 dlv_vec", int'(dlv_vec), m_vec);
      if (m_ipl)        chk("R5 ip_value", int'(ip_value), m_ip);
      if (m_state == 2) chk("R6 push_data", int'(push_data), m_err);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic raise(int v, int e, bit p, int ip);
    exc_req = 1; exc_vec = VW'(v); exc_err = EW'(e); prot_en = p; saved_ip = IW'(ip);
    step(1);
    exc_req = 0;
  endtask

  task automatic ack_entry(bit ok);
    dlv_ack = 1; dlv_ok = ok; step(1); dlv_ack = 0; dlv_ok = 0;
  endtask

  task automatic ack_push(bit ok);
    push_ack = 1; push_ok = ok; step(1); push_ack = 0; push_ok = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    // R6: code-carrying vector with protection, push succeeds
    raise(13, 32'h0000_ABCD, 1, 32'h1000); step(2); ack_entry(1); step(2); ack_push(1); step(1);
    chk("R7 cleared after push", int'(fault_depth), 0);
    // R6 boundaries: no code / protection off / vector above 31
    raise(9, 5, 1, 32'h2000); step(1); ack_entry(1); step(1);
    raise(15, 5, 1, 32'h2004); ack_entry(1); step(1);
    raise(18, 5, 1, 32'h2008); ack_entry(1); step(1);
    raise(13, 5, 0, 32'h200C); ack_entry(1); step(1);
    raise(45, 5, 1, 32'h2010); ack_entry(1); step(1);
    raise(17, 7, 1, 32'h2014); ack_entry(1); ack_push(1); step(1);
    // R7 entry failure keeps depth, R3 second fault becomes vector 8
    raise(3, 1, 1, 32'h3000); step(1); ack_entry(0); step(1);
    chk("R7 depth kept after fail", int'(fault_depth), 1);
    raise(5, 2, 1, 32'h3004); step(1);
    chk("R3 double fault vector", int'(dlv_vec), 8);
    ack_entry(1); ack_push(1); step(1);
    // R7 push failure keeps depth
    raise(14, 3, 1, 32'h4000); ack_entry(1); ack_push(0); step(1);
    chk("R7 depth kept after push fail", int'(fault_depth), 1);
    // R4 third fault resets
    raise(6, 0, 1, 32'h4004); ack_entry(0);
    raise(7, 0, 1, 32'h4008);
    chk("R4 core_rst pulse", int'(core_rst), 1);
    step(1);
    chk("R4 depth cleared", int'(fault_depth), 0);
    // R8 nested request during pending entry, with ack in same cycle
    raise(14, 9, 1, 32'h5000); step(2);
    dlv_ack = 1; dlv_ok = 1;
    raise(6, 4, 1, 32'h5004);
    dlv_ack = 0; dlv_ok = 0;
    chk("R8 nested depth", int'(fault_depth), 2);
    chk("R8 nested vector", int'(dlv_vec), 8);
    ack_entry(1); step(1); ack_push(1); step(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule